// File: doc/BRIEF.md
# SPI Serial Byte-Memory Slave

This block is the serial front end of a byte-addressed memory. An SPI master selects it with an active-low chip select and sends a one-byte command. For memory commands two address bytes follow. The block then streams bytes into or out of an external memory port, and the address advances by one after each byte. Writes are committed one byte at a time as soon as the eighth bit of a byte arrives. No page buffer is used. Read data is launched from the rising edge of the serial clock, so the master samples each bit on the following rising edge.

All pins are oversampled by the block's system clock. SPI modes 0 and 3 are accepted because every transfer is decided by rising serial-clock edges seen after chip select falls. The block holds no status or protection state. A companion block owns the write-enable latch, the status byte and the block-protection policy. This block sends it latch set/clear pulses and status-write strobes, and receives back the status byte and a per-address write permit. The memory itself sits outside and is reached through an address, a write strobe and a read-data port. The read-data port is sampled one system cycle after the address is presented.

Top module: `sermem_spi_slave`

## Requirements
- R1: While `rst_n` is low, `miso_oe` is 0 and no memory, status or latch strobe is issued. After release `miso_oe` is 1 and `miso` idles at 0.
- R2: Commands are taken from the first byte after chip select falls. 0x06 gives one `wel_set` pulse after chip select rises. 0x04, 0x01 and 0x02 each give one `wel_clr` pulse after chip select rises.
- R3: Command 0x02 is followed by two address bytes, sent MSB first. Only the low 13 bits are used. The first data byte is written to that address with bit 7 first, as a single one-cycle `mem_we`.
- R4: Each further data byte in a write burst goes to the next address. After 0x1FFF the next address is 0x0000.
- R5: Command 0x03 returns the addressed byte MSB first on the 8 serial clocks that follow the last address bit. `mosi` is ignored during read data.
- R6: A read burst continues at the next address for each further byte and wraps from 0x1FFF to 0x0000.
- R7: A write byte whose address has `wr_allow` low is not written, and the burst address still advances past it.
- R8: Bytes after a complete command in the same selection are never decoded as commands.
- R9: An unknown command byte causes the rest of the selection to be ignored, with `miso` held at 0 and no strobes.
- R10: Command 0x05 returns `status_in` MSB first on the next 8 serial clocks.
- R11: Command 0x01 takes one data byte and issues one `sr_we` pulse with that byte on `sr_wdata`.
- R12: Mode 3 framing (clock idle high at chip select fall) gives the same results as mode 0.
- R13: A reset asserted partway through a write byte aborts the operation: the partial byte is never written, and the interface works again after the next selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Active-low reset; holds the interface idle |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for `miso`; low only during reset |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe, one cycle per byte |
| mem_rdata | input | 8 | Memory read data for `mem_addr` |
| wr_allow | input | 1 | Companion permit for writing `mem_addr` |
| status_in | input | 8 | Status byte supplied by the companion |
| sr_we | output | 1 | Status write strobe |
| sr_wdata | output | 8 | Status byte written by the master |
| wel_set | output | 1 | Pulse: set the write-enable latch |
| wel_clr | output | 1 | Pulse: clear the write-enable latch |

## Verification
Write and read bursts are run at a mid-array address with the upper address bits set, and at the last address. This separates address truncation from wraparound. Reads are done with `mosi` held high during data, which shows that input is ignored while data is returned. One write burst has a single protected address in its middle. The bytes on either side of it show that suppression is per byte and that the address keeps advancing. Further selections cover: a second opcode after a complete command, an unknown opcode followed by a valid read frame, and the same write/read pair repeated in mode 3. A last selection has a reset arriving four bits into a data byte. Together these separate command latching from address handling and mode detection.

// File: rtl/sermem_pkg.sv
package sermem_pkg;

    localparam logic [7:0] OP_LATCH_ON  = 8'h06;
    localparam logic [7:0] OP_LATCH_OFF = 8'h04;
    localparam logic [7:0] OP_STAT_RD   = 8'h05;
    localparam logic [7:0] OP_STAT_WR   = 8'h01;
    localparam logic [7:0] OP_MEM_RD    = 8'h03;
    localparam logic [7:0] OP_MEM_WR    = 8'h02;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_SRWR,
        ST_SRRD,
        ST_SKIP
    } ser_state_e;

    typedef enum logic [1:0] {
        LATCH_NONE,
        LATCH_SET,
        LATCH_CLR
    } latch_req_e;

endpackage

// File: rtl/sermem_sync.sv
module sermem_sync #(
    parameter int                 WIDTH     = 3,
    parameter int                 STAGES    = 2,
    parameter logic [WIDTH-1:0]   RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RESET_VAL[b]}};
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_in[b]};
            end
        end

        assign sync_out[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/sermem_engine.sv
module sermem_engine
    import sermem_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int ADDR_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_lvl,
    input  logic              sck_lvl,
    input  logic              mosi_lvl,
    output logic              miso,
    output logic              miso_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    input  logic [7:0]        mem_rdata,
    input  logic              wr_allow,
    input  logic [7:0]        status_in,
    output logic              sr_we,
    output logic [7:0]        sr_wdata,
    output logic              wel_set,
    output logic              wel_clr
);

    localparam int ACNT_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam logic [ACNT_W-1:0] ABYTE_LAST = ACNT_W'(ADDR_BYTES - 1);

    typedef struct packed {
        ser_state_e        st;
        logic [2:0]        bitn;
        logic [7:0]        shin;
        logic [7:0]        shout;
        logic [ADDR_W-1:0] addr;
        logic [ACNT_W-1:0] abyte;
        logic              is_rd;
        logic              step;
        logic [7:0]        wbyte;
        latch_req_e        latch;
        logic              srwe;
        logic [7:0]        srdata;
        logic              wset;
        logic              wclr;
        logic              oe;
        logic              sck_p;
    } eng_state_t;

    eng_state_t q, d;

    logic       sck_rise;
    logic       last_bit;
    logic [7:0] byte_in;

    assign sck_rise = sck_lvl & ~q.sck_p;
    assign last_bit = (q.bitn == 3'd7);
    assign byte_in  = {q.shin[6:0], mosi_lvl};

    always_comb begin
        d       = q;
        d.sck_p = sck_lvl;
        d.srwe  = 1'b0;
        d.wset  = 1'b0;
        d.wclr  = 1'b0;
        d.step  = 1'b0;
        d.oe    = 1'b1;

        // commit or fetch one byte, then move to the next address
        if (q.step) begin
            d.addr = q.addr + 1'b1;
            if (q.st == ST_RDATA) begin
                d.shout = mem_rdata;
            end
        end

        if (cs_lvl) begin
            d.st    = ST_IDLE;
            d.bitn  = '0;
            d.shout = '0;
            if (q.st != ST_IDLE) begin
                d.wset = (q.latch == LATCH_SET);
                d.wclr = (q.latch == LATCH_CLR);
            end
            d.latch = LATCH_NONE;
        end else if (q.st == ST_IDLE) begin
            d.st    = ST_CMD;
            d.bitn  = '0;
            d.shout = '0;
        end else if (sck_rise) begin
            d.bitn = q.bitn + 1'b1;
            d.shin = byte_in;
            if ((q.st == ST_RDATA || q.st == ST_SRRD) && !last_bit) begin
                d.shout = {q.shout[6:0], 1'b0};
            end
            case (q.st)
                ST_CMD: begin
                    if (last_bit) begin
                        d.abyte = '0;
                        case (byte_in)
                            OP_LATCH_ON: begin
                                d.st    = ST_SKIP;
                                d.latch = LATCH_SET;
                            end
                            OP_LATCH_OFF: begin
                                d.st    = ST_SKIP;
                                d.latch = LATCH_CLR;
                            end
                            OP_STAT_RD: begin
                                d.st    = ST_SRRD;
                                d.shout = status_in;
                            end
                            OP_STAT_WR: begin
                                d.st    = ST_SRWR;
                                d.latch = LATCH_CLR;
                            end
                            OP_MEM_RD: begin
                                d.st    = ST_ADDR;
                                d.is_rd = 1'b1;
                            end
                            OP_MEM_WR: begin
                                d.st    = ST_ADDR;
                                d.is_rd = 1'b0;
                                d.latch = LATCH_CLR;
                            end
                            default: d.st = ST_SKIP;
                        endcase
                    end
                end
                ST_ADDR: begin
                    d.addr = {q.addr[ADDR_W-2:0], mosi_lvl};
                    if (last_bit) begin
                        if (q.abyte == ABYTE_LAST) begin
                            d.st   = q.is_rd ? ST_RDATA : ST_WDATA;
                            d.step = q.is_rd;
                        end else begin
                            d.abyte = q.abyte + 1'b1;
                        end
                    end
                end
                ST_WDATA: begin
                    if (last_bit) begin
                        d.wbyte = byte_in;
                        d.step  = 1'b1;
                    end
                end
                ST_RDATA: begin
                    if (last_bit) begin
                        d.step = 1'b1;
                    end
                end
                ST_SRRD: begin
                    if (last_bit) begin
                        d.shout = status_in;
                    end
                end
                ST_SRWR: begin
                    if (last_bit) begin
                        d.srwe   = 1'b1;
                        d.srdata = byte_in;
                        d.st     = ST_SKIP;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign miso      = q.shout[7];
    assign miso_oe   = q.oe;
    assign mem_addr  = q.addr;
    assign mem_wdata = q.wbyte;
    assign mem_we    = q.step & (q.st == ST_WDATA) & wr_allow;
    assign sr_we     = q.srwe;
    assign sr_wdata  = q.srdata;
    assign wel_set   = q.wset;
    assign wel_clr   = q.wclr;

endmodule

// File: rtl/sermem_spi_slave.sv
module sermem_spi_slave #(
    parameter int ADDR_W      = 13,
    parameter int ADDR_BYTES  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              mosi,
    output logic              miso,
    output logic              miso_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    input  logic [7:0]        mem_rdata,
    input  logic              wr_allow,
    input  logic [7:0]        status_in,
    output logic              sr_we,
    output logic [7:0]        sr_wdata,
    output logic              wel_set,
    output logic              wel_clr
);

    localparam int PIN_N = 3;

    logic [PIN_N-1:0] pins_s;

    sermem_sync #(
        .WIDTH     (PIN_N),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (3'b100)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({cs_n, sck, mosi}),
        .sync_out (pins_s)
    );

    sermem_engine #(
        .ADDR_W     (ADDR_W),
        .ADDR_BYTES (ADDR_BYTES)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_lvl    (pins_s[2]),
        .sck_lvl   (pins_s[1]),
        .mosi_lvl  (pins_s[0]),
        .miso      (miso),
        .miso_oe   (miso_oe),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .wr_allow  (wr_allow),
        .status_in (status_in),
        .sr_we     (sr_we),
        .sr_wdata  (sr_wdata),
        .wel_set   (wel_set),
        .wel_clr   (wel_clr)
    );

endmodule

// File: rtl/sermem_spi_slave_chk.sv
module sermem_spi_slave_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miso_oe,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              wr_allow,
    input logic              sr_we,
    input logic              wel_set,
    input logic              wel_clr
);

    // R1
    oe_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !miso_oe |=> miso_oe);

    // R7
    we_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wr_allow);

    // R3
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R4
    we_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

    // R11
    srwe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_we |=> !sr_we);

    // R2
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wel_set && wel_clr));

    // R8
    one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && sr_we));

endmodule

bind sermem_spi_slave sermem_spi_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .miso_oe  (miso_oe),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .wr_allow (wr_allow),
    .sr_we    (sr_we),
    .wel_set  (wel_set),
    .wel_clr  (wel_clr)
);

// File: tb/sermem_spi_slave_test.sv
module sermem_spi_slave_test;

    localparam int HALF = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sck = 1'b0;
    logic        mosi = 1'b0;
    logic        miso;
    logic        miso_oe;
    logic [12:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  mem_rdata = 8'h00;
    logic        wr_allow;
    logic [7:0]  status_in = 8'h00;
    logic        sr_we;
    logic [7:0]  sr_wdata;
    logic        wel_set;
    logic        wel_clr;

    int errors = 0;
    int checks = 0;
    int we_cnt = 0;
    int sr_cnt = 0;
    int set_cnt = 0;
    int clr_cnt = 0;
    logic [7:0]  sr_last = 8'h00;
    logic        prot_en = 1'b0;
    logic [12:0] prot_addr = 13'h0;
    logic        mode3 = 1'b0;
    logic [7:0]  mem [int];

    always #10 clk = ~clk;

    sermem_spi_slave uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sck       (sck),
        .mosi      (mosi),
        .miso      (miso),
        .miso_oe   (miso_oe),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .wr_allow  (wr_allow),
        .status_in (status_in),
        .sr_we     (sr_we),
        .sr_wdata  (sr_wdata),
        .wel_set   (wel_set),
        .wel_clr   (wel_clr)
    );

    assign wr_allow = !(prot_en && mem_addr == prot_addr);

    always @(posedge clk) begin
        if (mem_we) begin
            mem[int'(mem_addr)] = mem_wdata;
            we_cnt++;
        end
        if (sr_we) begin
            sr_cnt++;
            sr_last = sr_wdata;
        end
        if (wel_set) set_cnt++;
        if (wel_clr) clr_cnt++;
    end

    always @(negedge clk) begin
        mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
    end

    function automatic logic [7:0] peek(input int a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel_begin();
        @(negedge clk);
        sck = mode3;
        wait_clk(2 * HALF);
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic sel_end();
        if (!mode3) sck = 1'b0;
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(3 * HALF);
    endtask

    task automatic xbit(input logic b, output logic r);
        sck  = 1'b0;
        mosi = b;
        wait_clk(HALF);
        r    = miso;
        sck  = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            logic r;
            xbit(tx[i], r);
            rx[i] = r;
        end
    endtask

    task automatic send(input logic [7:0] tx);
        logic [7:0] rx;
        xbyte(tx, rx);
    endtask

    task automatic t_reset();
        wait_clk(3);
        chk("R1 oe in reset", int'(miso_oe), 0);
        chk("R1 no write in reset", we_cnt, 0);
        rst_n = 1'b1;
        wait_clk(4);
        chk("R1 oe after reset", int'(miso_oe), 1);
        chk("R1 miso idle", int'(miso), 0);
    endtask

    task automatic t_latch();
        int s0 = set_cnt;
        int c0 = clr_cnt;
        sel_begin(); send(8'h06); sel_end();
        chk("R2 set pulse", set_cnt - s0, 1);
        chk("R2 no clear on set", clr_cnt - c0, 0);
        sel_begin(); send(8'h04); sel_end();
        chk("R2 clear pulse", clr_cnt - c0, 1);
    endtask

    task automatic t_write_mid();
        int c0 = clr_cnt;
        sel_begin();
        send(8'h02); send(8'hE1); send(8'h23);
        send(8'hA5); send(8'h3C);
        sel_end();
        chk("R3 first byte, top bits ignored", int'(peek(32'h123)), 32'hA5);
        chk("R4 next byte", int'(peek(32'h124)), 32'h3C);
        chk("R2 clear after write", clr_cnt - c0, 1);
    endtask

    task automatic t_write_wrap();
        sel_begin();
        send(8'h02); send(8'h1F); send(8'hFF);
        send(8'h11); send(8'h22);
        sel_end();
        chk("R4 last address", int'(peek(32'h1FFF)), 32'h11);
        chk("R4 wrapped to zero", int'(peek(0)), 32'h22);
    endtask

    task automatic t_read(input logic [15:0] a, input logic [7:0] e0,
                          input logic [7:0] e1, input string req);
        logic [7:0] rx;
        sel_begin();
        xbyte(8'h03, rx);
        chk({req, " miso low during command"}, int'(rx), 0);
        send(a[15:8]); send(a[7:0]);
        xbyte(8'hFF, rx);
        chk({req, " byte 0"}, int'(rx), int'(e0));
        xbyte(8'hFF, rx);
        chk({req, " byte 1"}, int'(rx), int'(e1));
        sel_end();
    endtask

    task automatic t_protect();
        int w0 = we_cnt;
        mem[32'h201] = 8'h5E;
        prot_en   = 1'b1;
        prot_addr = 13'h201;
        sel_begin();
        send(8'h02); send(8'h02); send(8'h00);
        send(8'h01); send(8'h02); send(8'h03);
        sel_end();
        prot_en = 1'b0;
        chk("R7 unprotected before", int'(peek(32'h200)), 1);
        chk("R7 protected kept", int'(peek(32'h201)), 32'h5E);
        chk("R7 address advanced", int'(peek(32'h202)), 3);
        chk("R7 write count", we_cnt - w0, 2);
    endtask

    task automatic t_one_cmd();
        int s0 = set_cnt;
        int c0 = clr_cnt;
        int w0 = we_cnt;
        sel_begin();
        send(8'h06); send(8'h02); send(8'h00); send(8'h10); send(8'h99);
        sel_end();
        chk("R8 set once", set_cnt - s0, 1);
        chk("R8 no clear", clr_cnt - c0, 0);
        chk("R8 no write", we_cnt - w0, 0);
    endtask

    task automatic t_unknown();
        int s0 = set_cnt;
        int c0 = clr_cnt;
        int w0 = we_cnt;
        int orx = 0;
        logic [7:0] rx;
        sel_begin();
        xbyte(8'hAB, rx); orx |= rx;
        xbyte(8'h03, rx); orx |= rx;
        xbyte(8'h01, rx); orx |= rx;
        xbyte(8'h23, rx); orx |= rx;
        xbyte(8'hFF, rx); orx |= rx;
        sel_end();
        chk("R9 miso held low", orx, 0);
        chk("R9 no write", we_cnt - w0, 0);
        chk("R9 no latch pulses", (set_cnt - s0) + (clr_cnt - c0), 0);
    endtask

    task automatic t_status();
        logic [7:0] rx;
        int c0 = clr_cnt;
        int r0 = sr_cnt;
        status_in = 8'h8C;
        sel_begin();
        send(8'h05);
        xbyte(8'h00, rx);
        sel_end();
        chk("R10 status read", int'(rx), 32'h8C);
        sel_begin();
        send(8'h01); send(8'hB4); send(8'h77);
        sel_end();
        chk("R11 one status strobe", sr_cnt - r0, 1);
        chk("R11 status data", int'(sr_last), 32'hB4);
        chk("R2 clear after status write", clr_cnt - c0, 1);
    endtask

    task automatic t_mode3();
        mode3 = 1'b1;
        sel_begin();
        send(8'h02); send(8'h04); send(8'h56);
        send(8'hC3); send(8'h81);
        sel_end();
        chk("R12 mode 3 write", int'(peek(32'h456)), 32'hC3);
        t_read(16'h0456, 8'hC3, 8'h81, "R12 mode 3 read");
        mode3 = 1'b0;
    endtask

    task automatic t_abort();
        int w0;
        logic r;
        sel_begin();
        send(8'h02); send(8'h03); send(8'h00); send(8'h5A);
        sel_end();
        chk("R13 preload", int'(peek(32'h300)), 32'h5A);
        w0 = we_cnt;
        sel_begin();
        send(8'h02); send(8'h03); send(8'h00);
        for (int i = 0; i < 4; i++) xbit(1'b1, r);
        rst_n = 1'b0;
        wait_clk(3);
        chk("R13 oe off during reset", int'(miso_oe), 0);
        for (int i = 0; i < 4; i++) xbit(1'b1, r);
        sck  = 1'b0;
        cs_n = 1'b1;
        wait_clk(2 * HALF);
        rst_n = 1'b1;
        wait_clk(2 * HALF);
        chk("R13 no write from aborted byte", we_cnt - w0, 0);
        t_read(16'h0300, 8'h5A, 8'h00, "R13 after abort");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_latch();
        t_write_mid();
        t_write_wrap();
        t_read(16'hE123, 8'hA5, 8'h3C, "R5 read");
        t_read(16'h1FFF, 8'h11, 8'h22, "R6 read wrap");
        t_protect();
        t_one_cmd();
        t_unknown();
        t_status();
        t_mode3();
        t_abort();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule